// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the programmed contents of six base address registers into six address windows and classifies each incoming transaction address against them. When software writes a new address into one of the registers, the block forms that window's base from the written address bits, clears the low type bits, and relocates the result by one of two fixed space offsets: one for I/O windows and one for memory windows. Each window's length comes from a per-window size input. An all-ones write, which software uses to size the register, leaves the decoded window alone.

A transaction address presented with a valid strobe is compared against every enabled window at once. One cycle later the block reports whether any window matched, the index of the matching window (the lowest index when windows overlap) and the offset of the address from that window's base. Every write that moves a window raises a one-cycle range-change pulse so that routing logic can refresh its view of the address map.

Top module: `bar_window_decoder`

## Requirements
- R1: While reset is held and in the cycle after it, `hit_o`, `hit_idx_o`, `hit_off_o` and `range_chg_o` are all zero, and every window is disabled.
- R2: A write to window k (0 to 5) whose data is not all ones and whose address field is nonzero sets that window's base to the address field plus the space offset; the address field is the data with bits 1:0 cleared when `bar_io_i[k]` is 1 (I/O, offset `IO_SPACE_BASE`, default 0x0001_0000) and with bits 3:0 cleared when it is 0 (memory, offset `MEM_SPACE_BASE`, default 0x4000_0000).
- R3: Window k matches an address A when base <= A < base + size, where size is bits [32k+31:32k] of `win_size_i`; the upper bound is computed without wrap-around.
- R4: When several windows match, `hit_idx_o` reports the lowest matching index.
- R5: `hit_o`, `hit_idx_o` and `hit_off_o` are registered: they describe the request presented in the previous cycle; when that cycle had `req_valid_i` low or no match, `hit_o` is 0 and the index and offset are 0.
- R6: On a hit, `hit_off_o` equals the request address minus the matched window's base.
- R7: `range_chg_o` is high for exactly the one cycle after each write that updates a window (R2), and low otherwise.
- R8: A write of all ones (0xFFFF_FFFF) changes no window and raises no range-change pulse.
- R9: A write whose address field is zero changes no window and raises no range-change pulse.
- R10: A window whose base is zero (never programmed) never matches, even for addresses inside [0, size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Window index of the write (0 to 5; larger values ignored) |
| wr_data_i | input | 32 | Written register value |
| bar_io_i | input | 6 | Per-window type: 1 = I/O, 0 = memory |
| win_size_i | input | 192 | Per-window length, window k in bits [32k+31:32k] |
| req_valid_i | input | 1 | Transaction address valid |
| req_addr_i | input | 32 | Transaction address |
| hit_o | output | 1 | Previous-cycle request hit a window |
| hit_idx_o | output | 3 | Index of the matching window |
| hit_off_o | output | 32 | Offset of the address within the matching window |
| range_chg_o | output | 1 | One-cycle pulse after a window moves |

## Verification
Both results are one register stage away from their stimulus: a request driven before a rising edge shows its hit, index and offset after that edge, and a write shows its range-change pulse after the edge that takes it, returning low one edge later. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so every comparison sees the value produced by exactly one edge. A behavioural model updated on each rising edge predicts all four outputs, and they are compared every cycle alongside directed checks at window edges, overlaps, sizing writes and zero-field writes.

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
  parameter int NUM_WIN = 6,
  parameter int AW = 32,
  parameter int IDX_W = 3,
  parameter int IO_TYPE_BITS = 2,
  parameter int MEM_TYPE_BITS = 4,
  parameter logic [AW-1:0] IO_SPACE_BASE = 32'h0001_0000,
  parameter logic [AW-1:0] MEM_SPACE_BASE = 32'h4000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [AW-1:0]         wr_data_i,
  input  logic [NUM_WIN-1:0]    bar_io_i,
  input  logic [NUM_WIN*AW-1:0] win_size_i,
  input  logic                  req_valid_i,
  input  logic [AW-1:0]         req_addr_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      hit_idx_o,
  output logic [AW-1:0]         hit_off_o,
  output logic                  range_chg_o
);

  localparam logic [AW-1:0] IO_MASK  = {{(AW-IO_TYPE_BITS){1'b0}}, {IO_TYPE_BITS{1'b1}}};
  localparam logic [AW-1:0] MEM_MASK = {{(AW-MEM_TYPE_BITS){1'b0}}, {MEM_TYPE_BITS{1'b1}}};
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WIN-1);

  logic [AW-1:0] base_q [NUM_WIN];
  logic          wr_ok, wr_io, wr_take;
  logic [AW-1:0] wr_field, wr_base;

  assign wr_ok    = wr_idx_i <= LAST_IDX;
  assign wr_io    = wr_ok & bar_io_i[wr_idx_i];
  assign wr_field = wr_data_i & ~(wr_io ? IO_MASK : MEM_MASK);
  assign wr_base  = wr_field + (wr_io ? IO_SPACE_BASE : MEM_SPACE_BASE);
  assign wr_take  = wr_en_i && wr_ok && (wr_data_i != '1) && (wr_field != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) base_q[i] <= '0;
      range_chg_o <= 1'b0;
    end else begin
      if (wr_take) base_q[wr_idx_i] <= wr_base;
      range_chg_o <= wr_take;
    end
  end

  logic [NUM_WIN-1:0] match;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [AW:0] lim;
    assign lim = {1'b0, base_q[g]} + {1'b0, win_size_i[g*AW +: AW]};
    assign match[g] = (base_q[g] != '0) && (req_addr_i >= base_q[g]) &&
                      ({1'b0, req_addr_i} < lim);
  end

  logic             found;
  logic [IDX_W-1:0] sel_idx;
  logic [AW-1:0]    sel_base;

  always_comb begin
    found = 1'b0;
    sel_idx = '0;
    sel_base = '0;
    for (int i = NUM_WIN-1; i >= 0; i--) begin
      if (match[i]) begin
        found = 1'b1;
        sel_idx = IDX_W'(i);
        sel_base = base_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o <= 1'b0;
      hit_idx_o <= '0;
      hit_off_o <= '0;
    end else begin
      hit_o <= req_valid_i && found;
      hit_idx_o <= (req_valid_i && found) ? sel_idx : '0;
      hit_off_o <= (req_valid_i && found) ? req_addr_i - sel_base : '0;
    end
  end

  a_r5_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(req_valid_i));

  a_r5_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (hit_idx_o == '0) && (hit_off_o == '0));

  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> hit_idx_o <= LAST_IDX);

  a_r7_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    range_chg_o |-> $past(wr_en_i));

  a_r8_sizing_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i == '1) |=> !range_chg_o);

  a_r10_zero_base_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i == '0) |=> !hit_o);

endmodule

// File: tb/bar_window_decoder_tb.sv
`timescale 1ns/1ps
module bar_window_decoder_tb;
  localparam logic [31:0] IOB  = 32'h0001_0000;
  localparam logic [31:0] MEMB = 32'h4000_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_idx = '0;
  logic [31:0]  wr_data = '0;
  logic [5:0]   bar_io = 6'b000010;
  logic [191:0] win_size;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         hit, range_chg;
  logic [2:0]   hit_idx;
  logic [31:0]  hit_off;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  initial win_size = {32'h40, 32'h40, 32'h1000, 32'h10, 32'h20, 32'h100};

  bar_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .bar_io_i(bar_io), .win_size_i(win_size),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .hit_o(hit),
    .hit_idx_o(hit_idx), .hit_off_o(hit_off), .range_chg_o(range_chg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mbase [6];
  logic        e_hit, e_rc;
  logic [2:0]  e_idx;
  logic [31:0] e_off;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mbase[i]) mbase[i] = '0;
      e_hit = 0; e_rc = 0; e_idx = 0; e_off = 0;
    end else begin
      e_hit = 0; e_idx = 0; e_off = 0;
      if (req_valid) begin
        for (int w = 0; w < 6; w++) begin
          if (!e_hit && mbase[w] != 0 && req_addr >= mbase[w] &&
              (req_addr - mbase[w]) < win_size[w*32 +: 32]) begin
            e_hit = 1; e_idx = 3'(w); e_off = req_addr - mbase[w];
          end
        end
      end
      e_rc = 0;
      if (wr_en && wr_idx < 6 && wr_data != 32'hFFFF_FFFF) begin
        logic [31:0] f;
        f = bar_io[wr_idx] ? (wr_data & 32'hFFFF_FFFC) : (wr_data & 32'hFFFF_FFF0);
        if (f != 0) begin
          mbase[wr_idx] = f + (bar_io[wr_idx] ? IOB : MEMB);
          e_rc = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 model hit", {31'b0, hit}, {31'b0, e_hit});
      chk("R4 model idx", {29'b0, hit_idx}, {29'b0, e_idx});
      chk("R6 model off", hit_off, e_off);
      chk("R7 model range_chg", {31'b0, range_chg}, {31'b0, e_rc});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic look(input logic [31:0] a, input logic eh, input logic [2:0] ei,
                      input logic [31:0] eo, input string tag);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(tag, {31'b0, hit}, {31'b0, eh});
    chk(tag, {29'b0, hit_idx}, {29'b0, ei});
    chk(tag, hit_off, eo);
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d, input logic ep, input string tag);
    wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    chk(tag, {31'b0, range_chg}, {31'b0, ep});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset hit", {31'b0, hit}, 32'd0);
    chk("R1 reset range_chg", {31'b0, range_chg}, 32'd0);
    chk("R1 reset off", hit_off, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset hit", {31'b0, hit}, 32'd0);
    look(32'h0000_0010, 0, 0, 0, "R10 unprogrammed window at zero");
    look(MEMB, 0, 0, 0, "R10 unprogrammed window at space base");

    wr(0, 32'h0000_1008, 1, "R7 pulse on memory write");
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, range_chg}, 32'd0);
    look(32'h4000_1010, 1, 0, 32'h10, "R2 memory base masked");
    look(32'h4000_1000, 1, 0, 32'h0, "R3 lower edge");
    look(32'h4000_10FF, 1, 0, 32'hFF, "R3 last byte");
    look(32'h4000_1100, 0, 0, 0, "R3 upper bound excluded");
    look(32'h4000_0FFF, 0, 0, 0, "R3 below base");

    wr(1, 32'h0000_0205, 1, "R7 pulse on io write");
    look(32'h0001_0204, 1, 1, 32'h0, "R2 io base keeps bit2");
    look(32'h0001_0223, 1, 1, 32'h1F, "R6 io offset");

    wr(3, 32'h0000_1000, 1, "R7 pulse overlap write");
    look(32'h4000_1050, 1, 0, 32'h50, "R4 lowest index wins");
    look(32'h4000_1800, 1, 3, 32'h800, "R6 second window offset");

    wr(0, 32'hFFFF_FFFF, 0, "R8 sizing write no pulse");
    look(32'h4000_1020, 1, 0, 32'h20, "R8 window unchanged");

    wr(2, 32'h0000_0003, 0, "R9 zero field no pulse");
    look(MEMB, 0, 0, 0, "R9 window not enabled");

    req_valid = 0; req_addr = 32'h4000_1010;
    @(negedge clk);
    chk("R5 no valid no hit", {31'b0, hit}, 32'd0);

    wr(0, 32'h0000_2000, 1, "R7 reprogram pulse");
    look(32'h4000_1010, 1, 3, 32'h10, "R2 moved window");
    look(32'h4000_2004, 1, 0, 32'h4, "R2 new base");

    for (int k = 0; k < 40; k++) begin
      req_valid = k[0];
      req_addr = 32'h4000_1F00 + 32'(k * 97);
      wr_en = (k % 7 == 3);
      wr_idx = 3'(k % 8);
      wr_data = 32'h0000_3000 + 32'(k * 16);
      @(negedge clk);
    end
    req_valid = 0; wr_en = 0;
    repeat (2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule